// File: doc/BRIEF.md
# DDR2 Read Burst Scheduler

This block sits on the controller side of a DDR2 memory port. Read requests come in over a valid/ready handshake, and each one names a bank, a starting column and whether the row should be closed after the burst. The requests wait in a four-entry queue. Each one that targets a bank with an open row is turned into a READ command on the chip-select, row-strobe, column-strobe, write-enable, bank and address pins. A request to a bank with no open row is dropped. It raises a one-cycle error pulse and issues no command.

Queued reads leave one every BL/2 clocks, so the returning data stream has no gaps. A capture-window strobe is high in the cycle before the first data element (the preamble) and through the last data cycle of each burst. When bursts follow back to back, their windows merge into one continuous window. The block keeps one open-row flag per bank. A row-activation agent outside the block sets a flag by pulsing `row_opened`. A READ with auto-precharge clears the flag of its bank.

Read latency is RL = `cfg_al` + `cfg_cl`. The burst length is 4 when `cfg_bl8` is 0 and 8 when it is 1. These configuration inputs are static: they change only while the block is idle.

The sequencing is a two-state machine:

- ST_READY: a command can be issued in this state. When the queue head targets an open bank, the head is popped, a READ is issued and the machine moves to ST_SPACE (transition READY->SPACE). When the head targets a closed bank, it is popped and the error pulse is raised; the machine stays in ST_READY (transition READY->READY, reject).
- ST_SPACE: the machine counts down the gap to the next command. When the count ends, it returns to ST_READY (transition SPACE->READY), so the next decision falls exactly BL/2 clocks after the previous READ.

Top module: `ddr2_rd_sched`

## Requirements
- R1: A READ is driven as cs_n=0, ras_n=1, cas_n=0, we_n=1. Every other cycle is a NOP, driven as cs_n=0 with ras_n, cas_n and we_n all 1.
- R2: During a READ:
  - `ba` carries the request bank.
  - `addr[9:0]` carries the column.
  - `addr[10]` carries the auto-precharge flag.
  - All other address bits are 0.
  During a NOP, `ba` and `addr` are 0.
- R3: Suppose a request is accepted at a rising edge while the block is idle and its queue is empty. Its READ is then on the pins in the cycle that starts at the next rising edge, and it lasts that one cycle only.
- R4: Queued READs are issued exactly BL/2 cycles apart: 2 cycles when `cfg_bl8`=0, 4 cycles when `cfg_bl8`=1.
- R5: Take a READ on the pins in cycle c. `capture_win` is then high in cycles c+RL-1 through c+RL+BL/2-1, where RL = `cfg_al` + `cfg_cl`. It is low just before and just after that span unless another burst covers it.
- R6: The windows of back-to-back READs merge into one continuous high window with no low cycle.
- R7: Consider a request to a bank whose open-row flag is clear:
  - `miss_err` is high for one cycle, in the cycle a READ would have been on the pins.
  - No command is issued.
  - No spacing gap is consumed, so a following request can issue in the next cycle.
- R8: A READ with auto-precharge clears its bank's bit in `bank_open` in the same cycle the READ is on the pins. A READ without auto-precharge leaves the bit set.
- R9: A pulse on `row_opened[b]` sets `bank_open[b]` from the next cycle on. When that pulse and an auto-precharge clear hit the same bank at the same edge, the clear wins.
- R10: The queue holds four requests. `req_ready` is low while four are held, and requests are issued in arrival order.
- R11: After reset:
  - the pins drive NOP;
  - `capture_win` and `miss_err` are low;
  - all `bank_open` bits are 0;
  - `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Queue can accept a request |
| req_bank | input | 3 | Request bank |
| req_col | input | 10 | Request starting column |
| req_ap | input | 1 | Close the row after the burst |
| cfg_al | input | 3 | Additive latency |
| cfg_cl | input | 3 | CAS latency |
| cfg_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| row_opened | input | 8 | Per-bank pulse: a row was activated |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank pins |
| addr | output | 14 | Address pins |
| capture_win | output | 1 | Read data capture window |
| miss_err | output | 1 | Request to a closed bank was dropped |
| bank_open | output | 8 | Per-bank open-row flags |

## Verification
Two functions can land on the same edge: an activation pulse on `row_opened` and the auto-precharge clear of a READ to the same bank. The bench provokes this by queuing an auto-precharge read to an open bank and driving the pulse for exactly the edge at which that read issues. It then judges by `bank_open`: the bit must read 0 afterwards, and the READ must still appear with `addr[10]` high. The merging of back-to-back windows is the other overlap. The end of one burst's window and the start of the next fall in the same cycles, and the check is that no low cycle appears across the whole span.

// File: rtl/rd_sched_pkg.sv
package rd_sched_pkg;

    localparam int BANK_W = 3;
    localparam int COL_W  = 10;
    localparam int AP_BIT = 10;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              ap;
    } rd_req_t;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_SPACE = 1'b1
    } sched_state_e;

endpackage

// File: rtl/rd_fifo.sv
module rd_fifo
    import rd_sched_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  rd_req_t din,
    input  logic    pop,
    output rd_req_t dout,
    output logic    not_empty,
    output logic    not_full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rd_req_t         mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;

    assign not_empty = (cnt != '0);
    assign not_full  = (cnt != CW'(DEPTH));
    assign dout      = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push && !pop) cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < CW'(DEPTH) || pop));

    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));

endmodule

// File: rtl/rd_window.sv
module rd_window #(
    parameter int AL_W = 3,
    parameter int CL_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [AL_W-1:0] al,
    input  logic [CL_W-1:0] cl,
    input  logic            bl8,
    output logic            win
);
    localparam int MAX_RL = (1 << AL_W) - 1 + (1 << CL_W) - 1;
    localparam int N      = MAX_RL + 5;

    logic [N-1:0] sr, mask;
    int           rl_i, half_i;

    always_comb begin
        rl_i   = int'(al) + int'(cl);
        half_i = bl8 ? 4 : 2;
    end

    for (genvar k = 0; k < N; k++) begin : g_mask
        assign mask[k] = fire && ((k + 1) >= rl_i) && (k < (rl_i + half_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= (sr >> 1) | mask;
    end

    assign win = sr[0];

endmodule

// File: rtl/ddr2_rd_sched.sv
module ddr2_rd_sched
    import rd_sched_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int FIFO_DEPTH = 4,
    parameter int AL_W       = 3,
    parameter int CL_W       = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [BANK_W-1:0]         req_bank,
    input  logic [COL_W-1:0]          req_col,
    input  logic                      req_ap,
    input  logic [AL_W-1:0]           cfg_al,
    input  logic [CL_W-1:0]           cfg_cl,
    input  logic                      cfg_bl8,
    input  logic [(1<<BANK_W)-1:0]    row_opened,
    output logic                      cs_n,
    output logic                      ras_n,
    output logic                      cas_n,
    output logic                      we_n,
    output logic [BANK_W-1:0]         ba,
    output logic [ADDR_W-1:0]         addr,
    output logic                      capture_win,
    output logic                      miss_err,
    output logic [(1<<BANK_W)-1:0]    bank_open
);
    localparam int NBANK = 1 << BANK_W;

    rd_req_t            head;
    logic               head_v, decide, hit, fire, pop;
    logic [NBANK-1:0]   open_q, clr;
    sched_state_e       state, state_n;
    logic [1:0]         cnt, cnt_n;
    logic               rd_q, err_q;
    logic [BANK_W-1:0]  ba_q;
    logic [ADDR_W-1:0]  addr_q, addr_n;
    rd_req_t            in_req;

    assign in_req = '{bank: req_bank, col: req_col, ap: req_ap};

    rd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(req_valid && req_ready), .din(in_req),
        .pop(pop), .dout(head),
        .not_empty(head_v), .not_full(req_ready)
    );

    assign decide = (state == ST_READY) && head_v;
    assign hit    = open_q[head.bank];
    assign fire   = decide && hit;
    assign pop    = decide;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_READY: if (fire) begin
                state_n = ST_SPACE;
                cnt_n   = cfg_bl8 ? 2'd3 : 2'd1;
            end
            ST_SPACE: if (cnt == 2'd1) state_n = ST_READY;
                      else cnt_n = cnt - 2'd1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READY;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        addr_n = '0;
        addr_n[COL_W-1:0] = head.col;
        addr_n[AP_BIT]    = head.ap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            err_q  <= 1'b0;
            ba_q   <= '0;
            addr_q <= '0;
        end else begin
            rd_q   <= fire;
            err_q  <= decide && !hit;
            ba_q   <= fire ? head.bank : '0;
            addr_q <= fire ? addr_n : '0;
        end
    end

    assign clr = (fire && head.ap) ? (NBANK'(1) << head.bank) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= '0;
        else        open_q <= (open_q | row_opened) & ~clr;
    end

    rd_window #(.AL_W(AL_W), .CL_W(CL_W)) u_win (
        .clk(clk), .rst_n(rst_n), .fire(fire),
        .al(cfg_al), .cl(cfg_cl), .bl8(cfg_bl8), .win(capture_win)
    );

    assign cs_n      = 1'b0;
    assign ras_n     = 1'b1;
    assign cas_n     = !rd_q;
    assign we_n      = 1'b1;
    assign ba        = ba_q;
    assign addr      = addr_q;
    assign miss_err  = err_q;
    assign bank_open = open_q;

    logic [3:0] since_rd;
    logic       seen_rd;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rd <= '0;
            seen_rd  <= 1'b0;
        end else if (!cas_n) begin
            since_rd <= 4'd1;
            seen_rd  <= 1'b1;
        end else if (since_rd != 4'hF) begin
            since_rd <= since_rd + 4'd1;
        end
    end

    assert_read_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && seen_rd) |-> (since_rd >= (cfg_bl8 ? 4'd4 : 4'd2)));

    assert_open_bank_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> (($past(open_q) & (NBANK'(1) << ba)) != '0));

    assert_err_no_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_err |-> cas_n);

    assert_ap_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && addr[AP_BIT]) |-> ((bank_open & (NBANK'(1) << ba)) == '0));

    assert_nop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cas_n |-> (addr == '0 && ba == '0));

endmodule

// File: tb/tb_ddr2_rd_sched.sv
module tb_ddr2_rd_sched;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_ap = 0, cfg_bl8 = 0;
    logic [2:0]  req_bank = 0, cfg_al = 0, cfg_cl = 3;
    logic [9:0]  req_col = 0;
    logic [7:0]  row_opened = 0;
    logic        req_ready, cs_n, ras_n, cas_n, we_n, capture_win, miss_err;
    logic [2:0]  ba;
    logic [13:0] addr;
    logic [7:0]  bank_open;

    ddr2_rd_sched dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic        lg_rd [0:4095];
    logic        lg_win[0:4095];
    logic        lg_err[0:4095];
    logic        lg_rdy[0:4095];
    logic [13:0] lg_addr[0:4095];
    logic [2:0]  lg_ba[0:4095];

    always @(posedge clk) begin
        #1;
        cyc++;
        lg_rd[cyc]   = !cs_n && ras_n && !cas_n && we_n;
        lg_win[cyc]  = capture_win;
        lg_err[cyc]  = miss_err;
        lg_rdy[cyc]  = req_ready;
        lg_addr[cyc] = addr;
        lg_ba[cyc]   = ba;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int b, input int c, input bit ap, output int acc);
        @(negedge clk);
        req_valid = 1; req_bank = 3'(b); req_col = 10'(c); req_ap = ap;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        acc = cyc + 1;
        #1 req_valid = 0;
    endtask

    task automatic open_banks(input logic [7:0] m);
        @(negedge clk); row_opened = m;
        @(negedge clk); row_opened = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11 cas_n", cas_n, 1);
        chk("R11 ras_n/we_n/cs_n", {cs_n, ras_n, we_n}, 3'b011);
        chk("R11 capture_win", capture_win, 0);
        chk("R11 miss_err", miss_err, 0);
        chk("R11 bank_open", bank_open, 0);
        chk("R11 req_ready", req_ready, 1);
    endtask

    task automatic t_single;
        int a, r;
        cfg_al = 0; cfg_cl = 3; cfg_bl8 = 0;
        open_banks(8'h04);
        chk("R9 set by row_opened", bank_open[2], 1);
        push(2, 'h155, 0, a);
        repeat (12) @(negedge clk);
        r = a + 1;
        chk("R3 READ one cycle after accept", lg_rd[r], 1);
        chk("R3 READ single cycle", lg_rd[r+1], 0);
        chk("R1 NOP before READ", lg_rd[a], 0);
        chk("R2 bank pins", lg_ba[r], 2);
        chk("R2 address with A10 low", lg_addr[r], 'h155);
        chk("R2 address zero during NOP", lg_addr[r+1], 0);
        chk("R5 window low before preamble", lg_win[r+1], 0);
        for (int i = r + 2; i <= r + 4; i++) chk("R5 window high", lg_win[i], 1);
        chk("R5 window low after burst", lg_win[r+5], 0);
        chk("R8 no-AP keeps bank open", bank_open[2], 1);
    endtask

    task automatic t_b2b;
        int a, b, c, r;
        cfg_al = 1; cfg_cl = 4; cfg_bl8 = 1;
        open_banks(8'h02);
        push(1, 'h010, 0, a);
        push(1, 'h020, 0, b);
        push(1, 'h030, 1, c);
        repeat (30) @(negedge clk);
        r = a + 1;
        chk("R4 first READ", lg_rd[r], 1);
        chk("R4 second READ at BL/2", lg_rd[r+4], 1);
        chk("R4 no READ inside gap", lg_rd[r+2], 0);
        chk("R4 third READ at BL/2", lg_rd[r+8], 1);
        chk("R2 A10 high with AP", lg_addr[r+8], 'h430);
        chk("R6 window low before", lg_win[r+3], 0);
        begin
            int holes = 0;
            for (int i = r + 4; i <= r + 16; i++) if (!lg_win[i]) holes++;
            chk("R6 merged window holes", holes, 0);
        end
        chk("R6 window low after", lg_win[r+17], 0);
        chk("R8 AP clears bank", bank_open[1], 0);
    endtask

    task automatic t_reject;
        int a, b;
        push(6, 'h0AA, 0, a);
        push(2, 'h0BB, 0, b);
        repeat (10) @(negedge clk);
        chk("R7 error pulse", lg_err[a+1], 1);
        chk("R7 no command on reject", lg_rd[a+1], 0);
        chk("R7 error single cycle", lg_err[a+2], 0);
        chk("R7 next request issues at once", lg_rd[b+1], 1);
        chk("R7 next request bank", lg_ba[b+1], 2);
    endtask

    task automatic t_full;
        int a, x, k;
        int got[6];
        open_banks(8'h08);
        push(3, 'h10, 0, a);
        for (int i = 1; i < 6; i++) push(3, 'h10 + i, 0, x);
        repeat (40) @(negedge clk);
        chk("R10 ready high with three held", lg_rdy[a+3], 1);
        chk("R10 ready low with four held", lg_rdy[a+4], 0);
        k = 0;
        for (int i = a; i < a + 40; i++)
            if (lg_rd[i] && k < 6) begin got[k] = int'(lg_addr[i][9:0]); k++; end
        chk("R10 read count", k, 6);
        for (int i = 0; i < 6; i++) chk("R10 arrival order", got[i], 'h10 + i);
    endtask

    task automatic t_collide;
        int a;
        open_banks(8'h20);
        push(5, 'h077, 1, a);
        row_opened = 8'h20;
        @(posedge clk);
        #1 row_opened = 0;
        repeat (8) @(negedge clk);
        chk("R9 AP READ issued", lg_rd[a+1], 1);
        chk("R9 A10 on colliding READ", lg_addr[a+1][10], 1);
        chk("R9 clear wins over set", bank_open[5], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_single();
        t_b2b();
        t_reject();
        t_full();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule